// File: doc/BRIEF.md
# Minimum pulse width shaper

This block conditions one PWM channel on its way from a synchronized control input to a power-stage driver enable. It measures the length of every high pulse on the input and reshapes it before releasing it. Pulses too short to be trusted are removed. Pulses of moderate length are widened to a guaranteed minimum. Long pulses keep their length. Every output edge appears a fixed number of clock cycles after the input edge that caused it, so apart from the rejection and stretching regions the width response is a straight line shifted in time.

A second input comes from an external switching-transient detector. While that flag is high the output keeps its present level and cannot toggle. This prevents a disturbed phase node from re-triggering the driver. Because the shaping timers keep running underneath the hold, an output pulse can come out longer or shorter than its unblanked shape.

All widths and the latency are counted in clock cycles and set by parameters. The latency must be at least the reject width, so that the keep-or-drop decision for a pulse is made before the pulse reaches the output.

Top module: `pws_shaper`

## Requirements
- R1: While `rst_n` is low, `gate_en` is 0. A pulse that entered before reset never appears on `gate_en` after reset is released.
- R2: An input high pulse lasting fewer than REJECT_W clock cycles produces no output. Two short pulses separated by a single low cycle are rejected separately and are not merged.
- R3: An input high pulse of at least REJECT_W cycles and fewer than MIN_W cycles produces an output pulse exactly MIN_W cycles long.
- R4: An input high pulse of MIN_W cycles or more produces an output pulse of exactly the same number of cycles.
- R5: When not blanked, the output rises exactly PIPE_LAT clock cycles after the first cycle in which the input was sampled high.
- R6: If a qualified input pulse begins while the output is still high from a stretched pulse, the output stays high without a gap until the later of the two shaped pulses ends. A rejected pulse never extends an output.
- R7: When `blank_in` (active high) is sampled high at a clock edge, `gate_en` keeps the value it had before that edge.
- R8: When `blank_in` is sampled low, `gate_en` takes the shaped value for that edge. The stretch timer and the delay line keep advancing during blanking, so a blanked pulse can be shortened or removed entirely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all widths and the latency are counted in its cycles |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_in | input | 1 | Synchronized PWM request, active high |
| blank_in | input | 1 | Transient-detect flag, active high; freezes the output level |
| gate_en | output | 1 | Shaped driver enable, active high |

## Verification
The hardest case to reach is the interaction between a blanking window and the edges of a shaped pulse. The flag has to rise or fall within a few cycles of an output edge that itself lies PIPE_LAT cycles after the input edge. The stimulus therefore schedules the flag relative to the input pulse start, offset by the known latency. This places holds across the rising edge, across the falling edge, in the middle of the pulse, and over a whole stretched pulse. A second difficult case is a short pulse that is purged from the delay line right next to a qualified one. Back-to-back sequences with one- to three-cycle gaps cover it, and a behavioural model checks every cycle.

// File: rtl/pws_pkg.sv
package pws_pkg;

    localparam int unsigned DEF_REJECT_W = 20;
    localparam int unsigned DEF_MIN_W    = 30;
    localparam int unsigned DEF_LAT      = 24;

    // bits needed to hold values 0..max_val
    function automatic int unsigned cnt_bits(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/pws_width_filter.sv
// Delays the input by LAT cycles and purges, while still inside the
// delay line, any high run that ended before reaching REJECT_W cycles.
module pws_width_filter import pws_pkg::*; #(
    parameter int unsigned REJECT_W = DEF_REJECT_W,
    parameter int unsigned LAT      = DEF_LAT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_i,
    output logic dly_o
);

    localparam int unsigned RW = cnt_bits(REJECT_W);

    typedef struct packed {
        logic [LAT-1:0] line;
        logic [RW-1:0]  run;
    } flt_t;

    flt_t s_d, s_q;
    logic fall_short;

    always_comb begin
        s_d        = s_q;
        fall_short = !pwm_i && s_q.line[0] && (s_q.run < RW'(REJECT_W));
        s_d.line   = {s_q.line[LAT-2:0], pwm_i};
        for (int i = 1; i < int'(LAT); i++) begin
            if (fall_short && (i <= int'(s_q.run))) begin
                s_d.line[i] = 1'b0;
            end
        end
        if (!pwm_i) begin
            s_d.run = '0;
        end else if (s_q.run != RW'(REJECT_W)) begin
            s_d.run = s_q.run + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dly_o = s_q.line[LAT-1];

    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.run <= RW'(REJECT_W)); // R2

endmodule

// File: rtl/pws_stretcher.sv
// Holds the shaped level high for at least MIN_W cycles from each rise
// of the filtered stream; a new rise reloads the hold.
module pws_stretcher import pws_pkg::*; #(
    parameter int unsigned MIN_W = DEF_MIN_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dly_i,
    output logic busy_o,
    output logic ideal_o
);

    localparam int unsigned SW = cnt_bits(MIN_W - 1);

    typedef struct packed {
        logic          prev;
        logic [SW-1:0] left;
    } str_t;

    str_t s_d, s_q;
    logic rise;

    always_comb begin
        s_d      = s_q;
        s_d.prev = dly_i;
        rise     = dly_i && !s_q.prev;
        if (rise) begin
            s_d.left = SW'(MIN_W - 1);
        end else if (s_q.left != '0) begin
            s_d.left = s_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o  = (s_q.left != '0);
    assign ideal_o = dly_i | busy_o;

    AST_STRETCH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.left <= SW'(MIN_W - 1)); // R3

endmodule

// File: rtl/pws_shaper.sv
module pws_shaper import pws_pkg::*; #(
    parameter int unsigned REJECT_W = DEF_REJECT_W,
    parameter int unsigned MIN_W    = DEF_MIN_W,
    parameter int unsigned PIPE_LAT = DEF_LAT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_in,
    input  logic blank_in,
    output logic gate_en
);

    typedef struct packed {
        logic drive;
    } out_t;

    out_t s_d, s_q;
    logic dly;
    logic busy;
    logic ideal;

    pws_width_filter #(
        .REJECT_W (REJECT_W),
        .LAT      (PIPE_LAT)
    ) filt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .pwm_i (pwm_in),
        .dly_o (dly)
    );

    pws_stretcher #(
        .MIN_W (MIN_W)
    ) strt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .dly_i   (dly),
        .busy_o  (busy),
        .ideal_o (ideal)
    );

    always_comb begin
        s_d = s_q;
        if (!blank_in) begin
            s_d.drive = ideal;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign gate_en = s_q.drive;

    AST_BLANK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        blank_in |=> $stable(gate_en)); // R7

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!blank_in && !dly && !busy) |=> !gate_en); // R2

    AST_FOLLOW_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!blank_in && dly) |=> gate_en); // R4

    AST_STRETCH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!blank_in && busy) |=> gate_en); // R3

endmodule

// File: tb/pws_shaper_tb.sv
module pws_shaper_tb_top;

    localparam int R_W  = 20;
    localparam int M_W  = 30;
    localparam int LAT  = 24;
    localparam int HMAX = 16384;
    localparam int GAP  = LAT + M_W + 10;

    logic clk      = 1'b0;
    logic rst_n    = 1'b0;
    logic pwm_in   = 1'b0;
    logic blank_in = 1'b0;
    logic gate_en;

    always #2 clk = ~clk;

    pws_shaper #(
        .REJECT_W (R_W),
        .MIN_W    (M_W),
        .PIPE_LAT (LAT)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwm_in   (pwm_in),
        .blank_in (blank_in),
        .gate_en  (gate_en)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    bit    ideal [HMAX];
    int    n      = 0;
    int    run    = 0;
    int    start  = 0;
    logic  exp_out = 1'b0;
    string tag    = "R1";

    task automatic check(input logic act, input logic expv, input string req, input string what);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s %s: got %b expected %b", req, what, act, expv);
        end
    endtask

    task automatic check_int(input int act, input int expv, input string req, input string what);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic mark(input int idx);
        if (idx >= 0 && idx < HMAX) ideal[idx] = 1'b1;
    endtask

    task automatic model_clear();
        foreach (ideal[i]) ideal[i] = 1'b0;
        n       = 0;
        run     = 0;
        exp_out = 1'b0;
    endtask

    // one clock: drive at negedge, advance the model, compare at next negedge
    task automatic tick(input logic p, input logic b);
        pwm_in   = p;
        blank_in = b;
        if (p) begin
            run++;
            if (run == 1) start = n;
            if (run >= R_W) mark(start + LAT + run - 1);
            if (run == R_W) begin
                for (int k = 0; k < M_W; k++) mark(start + LAT + k);
            end
        end else begin
            run = 0;
        end
        if (!b) exp_out = (n < HMAX) ? ideal[n] : 1'b0;
        n++;
        @(negedge clk);
        check(gate_en, exp_out, tag, $sformatf("cycle %0d", n));
    endtask

    task automatic pulse(input int w, input int gap);
        repeat (w) tick(1'b1, 1'b0);
        repeat (gap) tick(1'b0, 1'b0);
    endtask

    task automatic do_reset();
        rst_n    = 1'b0;
        pwm_in   = 1'b0;
        blank_in = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check(gate_en, 1'b0, "R1", "gate_en during reset");
        end
        rst_n = 1'b1;
        model_clear();
    endtask

    // isolated pulse with explicit latency and width measurement
    task automatic measured(input int w);
        int rise_at = -1;
        int hi      = 0;
        int want;
        want = (w < R_W) ? 0 : ((w < M_W) ? M_W : w);
        tag  = (w < R_W) ? "R2" : ((w < M_W) ? "R3" : "R4");
        for (int t = 0; t < w + GAP; t++) begin
            tick(t < w, 1'b0);
            if (gate_en === 1'b1) begin
                if (rise_at < 0) rise_at = t;
                hi++;
            end
        end
        check_int(hi, want, tag, $sformatf("output width for input width %0d", w));
        if (want > 0) check_int(rise_at, LAT, "R5", $sformatf("rise latency for width %0d", w));
    endtask

    initial begin
        @(negedge clk);
        do_reset();

        // R1: qualified pulse in flight when reset hits must vanish
        tag = "R1";
        repeat (22) tick(1'b1, 1'b0);
        do_reset();
        tag = "R1";
        repeat (LAT + M_W + 20) tick(1'b0, 1'b0);

        // R2 R3 R4 R5: sweep across the three width regions
        for (int w = 1; w <= 45; w++) measured(w);

        // R2: short pulses with one-cycle gaps stay rejected
        tag = "R2";
        pulse(10, 1);
        pulse(12, 1);
        pulse(R_W - 1, GAP);

        // R6: overlapping and adjacent sequences
        tag = "R6";
        pulse(22, 3);
        pulse(22, GAP);
        pulse(25, 2);
        pulse(5, GAP);
        pulse(5, 2);
        pulse(25, GAP);
        pulse(40, 3);
        pulse(40, GAP);
        pulse(R_W, 1);
        pulse(R_W, GAP);

        // R7: holds across rise, middle and fall of a long pulse
        tag = "R7";
        for (int t = 0; t < 40 + GAP + 10; t++) begin
            tick(t < 40,
                 (t >= LAT - 3 && t < LAT + 2) ||
                 (t >= LAT + 10 && t < LAT + 15) ||
                 (t >= LAT + 38 && t < LAT + 45));
        end

        // R8: release mid-stretch shortens; full cover swallows
        tag = "R8";
        for (int t = 0; t < 22 + GAP; t++) begin
            tick(t < 22, (t >= LAT - 2 && t < LAT + 20));
        end
        for (int t = 0; t < 22 + GAP; t++) begin
            tick(t < 22, (t >= LAT - 2 && t < LAT + M_W + 3));
        end
        for (int t = 0; t < 35 + GAP; t++) begin
            tick(t < 35, (t >= LAT + 30 && t < LAT + 33));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule